// File: doc/BRIEF.md
# Vector Floating-Point Exception Trap Unit

This block sits after the lanes of a two-lane, 64-bit vector floating-point operation and decides what happens to the IEEE exception flags those lanes raised. Each lane delivers one flag byte. The block masks that byte with the trap-enable byte of the floating-point control word and walks the lanes in ascending order. It stops either at the first lane that traps or, in single-element mode, after lane 0.

The block returns one registered response one cycle after the request strobe. If a processed lane traps, the response carries an 8-bit trap code. The element index sits in the upper nibble and a prioritized cause sits in the lower nibble. The control word and the destination vector are then left alone. If no lane traps, the flags of every processed lane are ORed together and merged into the flag byte of the control word, and the destination write is allowed.

An inexact-suppress input stops a lane whose only enabled exception is inexact from trapping. A widening input doubles the reported element index, for operations whose source elements are half-width and taken from even positions.

Top module: `vfp_trap_unit`

## Requirements
- R1: After reset, and in every cycle with no response, `rsp_valid`, `trap_valid`, `trap_code`, `fpc_we`, `dest_we` and `lane_done` are all zero.
- R2: A request accepted with `in_valid` high at a clock edge produces `rsp_valid` high in the following cycle, and only then.
- R3: Lane 0 flags are `lane_flags[7:0]` and lane 1 flags are `lane_flags[15:8]`. In each flag byte and in the trap-enable byte `fpc_in[31:24]`: invalid is bit 7, divide-by-zero is bit 6, overflow is bit 5, underflow is bit 4 and inexact is bit 3. Bits 2:0 have no effect on any output. A lane traps when its flag byte ANDed with the enable byte is nonzero.
- R4: Cause codes are invalid=1, divide-by-zero=2, overflow=3, underflow=4 and inexact=5. When several enabled exceptions occur in one lane, the cause is chosen in that same order of priority, with inexact lowest.
- R5: `trap_code` equals (element index << 4) | cause when `trap_valid` is high. It is 0 in any response without a trap.
- R6: With `inexact_sup` high, a lane whose only enabled exception is inexact does not trap. Its flags still accumulate and processing continues.
- R7: Lanes are processed in the order 0 then 1, and processing stops after a trapping lane. `lane_done` bit i is high when lane i was processed. The trap code names the lowest processed lane that traps.
- R8: With `single_elem` high, only lane 0 is processed, so `lane_done` is 1 and lane 1 can neither trap nor contribute flags.
- R9: With `widen` high, the element index in the trap code is twice the lane number; otherwise it is the lane number.
- R10: A response without a trap has `fpc_we` and `dest_we` high, and `fpc_out` equals `fpc_in` ORed with (OR of the processed lanes' flags with bits 2:0 cleared) << 16.
- R11: A trapping response has `fpc_we` and `dest_we` low, and `fpc_out` equals the request's `fpc_in`.
- R12: A lane whose flag byte is zero (bits 7:3) never traps and adds nothing to the flags of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| lane_flags | input | 16 | Per-lane exception flag bytes, lane 0 in the low byte |
| fpc_in | input | 32 | Current control word (trap enables in 31:24, flags in 23:16) |
| single_elem | input | 1 | Process lane 0 only |
| inexact_sup | input | 1 | Suppress traps caused only by inexact |
| widen | input | 1 | Report element index as twice the lane number |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| trap_valid | output | 1 | A processed lane trapped |
| trap_code | output | 8 | Element index in bits 7:4, cause in bits 3:0 |
| fpc_we | output | 1 | Write `fpc_out` back to the control word |
| fpc_out | output | 32 | Updated control word |
| dest_we | output | 1 | Destination vector may be written |
| lane_done | output | 2 | Mask of lanes processed for this response |

## Verification
The checker assumes that `in_valid` is sampled only at clock edges, and that `lane_flags`, `fpc_in` and the three mode bits are stable around each edge where a request is taken. The bench meets this by changing every input on the falling edge. The assertions also assume that back-to-back requests are legal and that each one is independent of the previous one. The bench therefore sends requests one after another with idle cycles between them, so that the quiet state between responses is checked too. The random stimulus draws every flag byte and enable byte from the full 8-bit range, and the mode bits are free. This keeps the ignored low bits and all priority combinations inside what the checker expects.

// File: rtl/vfp_trap_pkg.sv
package vfp_trap_pkg;

  localparam int FLAGW  = 8;
  localparam int CAUSEW = 4;
  localparam int IDXW   = 4;

  localparam int BIT_INV = 7;
  localparam int BIT_DVZ = 6;
  localparam int BIT_OVF = 5;
  localparam int BIT_UNF = 4;
  localparam int BIT_INX = 3;

  localparam logic [FLAGW-1:0] FLAG_USED = 8'hF8;
  localparam logic [FLAGW-1:0] FLAG_INX  = 8'h08;

  typedef enum logic [CAUSEW-1:0] {
    CAUSE_NONE = 4'd0,
    CAUSE_INV  = 4'd1,
    CAUSE_DVZ  = 4'd2,
    CAUSE_OVF  = 4'd3,
    CAUSE_UNF  = 4'd4,
    CAUSE_INX  = 4'd5
  } cause_e;

  // Keep only the architected flag bits of a byte.
  function automatic logic [FLAGW-1:0] clean_flags(input logic [FLAGW-1:0] f);
    return f & FLAG_USED;
  endfunction

  // Pick the highest priority enabled exception.
  function automatic cause_e pick_cause(input logic [FLAGW-1:0] en);
    cause_e c;
    c = CAUSE_NONE;
    if (en[BIT_INV])      c = CAUSE_INV;
    else if (en[BIT_DVZ]) c = CAUSE_DVZ;
    else if (en[BIT_OVF]) c = CAUSE_OVF;
    else if (en[BIT_UNF]) c = CAUSE_UNF;
    else if (en[BIT_INX]) c = CAUSE_INX;
    return c;
  endfunction

  // Combine element index and cause into a trap code.
  function automatic logic [IDXW+CAUSEW-1:0] make_code(input logic [IDXW-1:0] idx,
                                                       input cause_e c);
    return {idx, c};
  endfunction

endpackage

// File: rtl/vfp_trap_lane.sv
module vfp_trap_lane
  import vfp_trap_pkg::*;
(
  input  logic [FLAGW-1:0] flags,
  input  logic [FLAGW-1:0] enables,
  input  logic             inexact_sup,
  output logic [FLAGW-1:0] flags_clean,
  output logic             lane_trap,
  output cause_e           lane_cause
);

  logic [FLAGW-1:0] enabled_raw;
  logic [FLAGW-1:0] enabled_eff;

  always_comb begin
    flags_clean = clean_flags(flags);
    enabled_raw = flags_clean & enables;
    enabled_eff = inexact_sup ? (enabled_raw & ~FLAG_INX) : enabled_raw;
    lane_trap   = |enabled_eff;
    lane_cause  = pick_cause(enabled_eff);
  end

endmodule

// File: rtl/vfp_trap_chain.sv
module vfp_trap_chain
  import vfp_trap_pkg::*;
#(
  parameter int NLANES = 2
) (
  input  logic [NLANES*FLAGW-1:0]  lane_flags_clean,
  input  logic [NLANES-1:0]        lane_trap,
  input  logic [NLANES*CAUSEW-1:0] lane_cause,
  input  logic                     single_elem,
  input  logic                     widen,
  output logic [NLANES-1:0]        lane_done,
  output logic [NLANES-1:0]        lane_hit,
  output logic                     any_trap,
  output logic [IDXW+CAUSEW-1:0]   code,
  output logic [FLAGW-1:0]         acc_flags
);

  localparam int CODEW = IDXW + CAUSEW;

  logic [NLANES:0]            go;
  logic [NLANES*CODEW-1:0]    lane_code;
  logic [NLANES*FLAGW-1:0]    lane_contrib;

  assign go[0] = 1'b1;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam logic [IDXW-1:0] LIDX = IDXW'(i);
    logic [IDXW-1:0] idx;
    cause_e          c;
    assign idx       = widen ? (LIDX << 1) : LIDX;
    assign c         = cause_e'(lane_cause[i*CAUSEW +: CAUSEW]);
    assign lane_done[i] = go[i];
    assign lane_hit[i]  = go[i] & lane_trap[i];
    assign go[i+1]   = go[i] & ~lane_trap[i] & ~single_elem;
    assign lane_code[i*CODEW +: CODEW] =
      lane_hit[i] ? make_code(idx, c) : '0;
    assign lane_contrib[i*FLAGW +: FLAGW] =
      go[i] ? lane_flags_clean[i*FLAGW +: FLAGW] : '0;
  end

  always_comb begin
    code      = '0;
    acc_flags = '0;
    for (int k = 0; k < NLANES; k++) begin
      code      = code | lane_code[k*CODEW +: CODEW];
      acc_flags = acc_flags | lane_contrib[k*FLAGW +: FLAGW];
    end
    any_trap = |lane_hit;
  end

endmodule

// File: rtl/vfp_trap_commit.sv
module vfp_trap_commit
  import vfp_trap_pkg::*;
#(
  parameter int NLANES   = 2,
  parameter int CTRLW    = 32,
  parameter int FLAG_LSB = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [CTRLW-1:0]       fpc_in,
  input  logic                   any_trap,
  input  logic [IDXW+CAUSEW-1:0] code,
  input  logic [FLAGW-1:0]       acc_flags,
  input  logic [NLANES-1:0]      done_mask,
  output logic                   rsp_valid,
  output logic                   trap_valid,
  output logic [IDXW+CAUSEW-1:0] trap_code,
  output logic                   fpc_we,
  output logic [CTRLW-1:0]       fpc_out,
  output logic                   dest_we,
  output logic [NLANES-1:0]      lane_done
);

  logic [CTRLW-1:0] merged;

  always_comb begin
    merged = fpc_in | (CTRLW'(acc_flags) << FLAG_LSB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      trap_valid <= 1'b0;
      trap_code  <= '0;
      fpc_we     <= 1'b0;
      fpc_out    <= '0;
      dest_we    <= 1'b0;
      lane_done  <= '0;
    end else if (in_valid) begin
      rsp_valid  <= 1'b1;
      trap_valid <= any_trap;
      trap_code  <= any_trap ? code : '0;
      fpc_we     <= ~any_trap;
      fpc_out    <= any_trap ? fpc_in : merged;
      dest_we    <= ~any_trap;
      lane_done  <= done_mask;
    end else begin
      rsp_valid  <= 1'b0;
      trap_valid <= 1'b0;
      trap_code  <= '0;
      fpc_we     <= 1'b0;
      dest_we    <= 1'b0;
      lane_done  <= '0;
    end
  end

endmodule

// File: rtl/vfp_trap_unit.sv
module vfp_trap_unit
  import vfp_trap_pkg::*;
#(
  parameter int NLANES   = 2,
  parameter int CTRLW    = 32,
  parameter int MASK_LSB = 24,
  parameter int FLAG_LSB = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NLANES*FLAGW-1:0]   lane_flags,
  input  logic [CTRLW-1:0]          fpc_in,
  input  logic                      single_elem,
  input  logic                      inexact_sup,
  input  logic                      widen,
  output logic                      rsp_valid,
  output logic                      trap_valid,
  output logic [IDXW+CAUSEW-1:0]    trap_code,
  output logic                      fpc_we,
  output logic [CTRLW-1:0]          fpc_out,
  output logic                      dest_we,
  output logic [NLANES-1:0]         lane_done
);

  logic [FLAGW-1:0]          trap_enables;
  logic [NLANES*FLAGW-1:0]   flags_clean;
  logic [NLANES-1:0]         lane_trap;
  logic [NLANES*CAUSEW-1:0]  lane_cause;
  logic [NLANES-1:0]         done_mask;
  logic [NLANES-1:0]         lane_hit;
  logic                      any_trap;
  logic [IDXW+CAUSEW-1:0]    code;
  logic [FLAGW-1:0]          acc_flags;

  assign trap_enables = fpc_in[MASK_LSB +: FLAGW];

  for (genvar i = 0; i < NLANES; i++) begin : g_eval
    cause_e c;
    vfp_trap_lane u_lane (
      .flags       (lane_flags[i*FLAGW +: FLAGW]),
      .enables     (trap_enables),
      .inexact_sup (inexact_sup),
      .flags_clean (flags_clean[i*FLAGW +: FLAGW]),
      .lane_trap   (lane_trap[i]),
      .lane_cause  (c)
    );
    assign lane_cause[i*CAUSEW +: CAUSEW] = c;
  end

  vfp_trap_chain #(.NLANES(NLANES)) u_chain (
    .lane_flags_clean (flags_clean),
    .lane_trap        (lane_trap),
    .lane_cause       (lane_cause),
    .single_elem      (single_elem),
    .widen            (widen),
    .lane_done        (done_mask),
    .lane_hit         (lane_hit),
    .any_trap         (any_trap),
    .code             (code),
    .acc_flags        (acc_flags)
  );

  vfp_trap_commit #(.NLANES(NLANES), .CTRLW(CTRLW), .FLAG_LSB(FLAG_LSB)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .fpc_in     (fpc_in),
    .any_trap   (any_trap),
    .code       (code),
    .acc_flags  (acc_flags),
    .done_mask  (done_mask),
    .rsp_valid  (rsp_valid),
    .trap_valid (trap_valid),
    .trap_code  (trap_code),
    .fpc_we     (fpc_we),
    .fpc_out    (fpc_out),
    .dest_we    (dest_we),
    .lane_done  (lane_done)
  );

endmodule

// File: rtl/vfp_trap_chk.sv
module vfp_trap_chk #(
  parameter int NLANES = 2,
  parameter int CTRLW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              single_elem,
  input logic [CTRLW-1:0]  fpc_in,
  input logic              rsp_valid,
  input logic              trap_valid,
  input logic [7:0]        trap_code,
  input logic              fpc_we,
  input logic [CTRLW-1:0]  fpc_out,
  input logic              dest_we,
  input logic [NLANES-1:0] lane_done
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!trap_valid && !fpc_we && !dest_we && trap_code == 8'd0 && lane_done == '0)); // R1

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> rsp_valid); // R2

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !rsp_valid); // R2

  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_code[3:0] >= 4'd1 && trap_code[3:0] <= 4'd5)); // R4

  AST_CODE_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !trap_valid) |-> (trap_code == 8'd0)); // R5

  AST_LANE0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> lane_done[0]); // R7

  AST_SINGLE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && single_elem) |=> (lane_done == NLANES'(1))); // R8

  AST_COMMIT_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!fpc_we || ((fpc_out & $past(fpc_in)) == $past(fpc_in)))); // R10

  AST_CLEAN_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !trap_valid) |-> (fpc_we && dest_we)); // R10

  AST_TRAP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!fpc_we && !dest_we)); // R11

  AST_TRAP_KEEPS_FPC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid ##1 trap_valid) |-> (fpc_out == $past(fpc_in))); // R11

endmodule

bind vfp_trap_unit vfp_trap_chk #(.NLANES(NLANES), .CTRLW(CTRLW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .single_elem (single_elem),
  .fpc_in      (fpc_in),
  .rsp_valid   (rsp_valid),
  .trap_valid  (trap_valid),
  .trap_code   (trap_code),
  .fpc_we      (fpc_we),
  .fpc_out     (fpc_out),
  .dest_we     (dest_we),
  .lane_done   (lane_done)
);

// File: tb/vfp_trap_unit_tb.sv
`timescale 1ns/1ps
module vfp_trap_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] lane_flags = '0;
  logic [31:0] fpc_in = '0;
  logic        single_elem = 1'b0;
  logic        inexact_sup = 1'b0;
  logic        widen = 1'b0;
  logic        rsp_valid, trap_valid, fpc_we, dest_we;
  logic [7:0]  trap_code;
  logic [31:0] fpc_out;
  logic [1:0]  lane_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vfp_trap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_flags(lane_flags),
    .fpc_in(fpc_in), .single_elem(single_elem), .inexact_sup(inexact_sup),
    .widen(widen), .rsp_valid(rsp_valid), .trap_valid(trap_valid),
    .trap_code(trap_code), .fpc_we(fpc_we), .fpc_out(fpc_out),
    .dest_we(dest_we), .lane_done(lane_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent restatement of the trap rules.
  function automatic logic [3:0] cause_of(input logic [7:0] en);
    for (int b = 7; b >= 3; b--)
      if (en[b]) return 4'(8 - b);
    return 4'd0;
  endfunction

  task automatic model(input logic [15:0] fl, input logic [31:0] fpc,
                       input bit sgl, input bit sup, input bit wd,
                       output bit e_trap, output logic [7:0] e_code,
                       output logic [31:0] e_fpc, output logic [1:0] e_done);
    logic [7:0] acc;
    acc = 8'h00; e_trap = 1'b0; e_code = 8'h00; e_done = 2'b00;
    for (int l = 0; l < 2; l++) begin
      logic [7:0] f, en;
      f  = fl[l*8 +: 8] & 8'b1111_1000;
      e_done[l] = 1'b1;
      acc = acc | f;
      en = f & fpc[31:24];
      if (sup) en[3] = 1'b0;
      if (en != 8'h00) begin
        e_trap = 1'b1;
        e_code = {4'(wd ? 2*l : l), cause_of(en)};
        break;
      end
      if (sgl) break;
    end
    e_fpc = e_trap ? fpc : (fpc | {8'h00, acc, 16'h0000});
  endtask

  task automatic run(input logic [15:0] fl, input logic [31:0] fpc,
                     input bit sgl, input bit sup, input bit wd, input string req);
    bit e_trap; logic [7:0] e_code; logic [31:0] e_fpc; logic [1:0] e_done;
    model(fl, fpc, sgl, sup, wd, e_trap, e_code, e_fpc, e_done);
    @(negedge clk);
    in_valid = 1'b1; lane_flags = fl; fpc_in = fpc;
    single_elem = sgl; inexact_sup = sup; widen = wd;
    @(negedge clk);
    in_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(trap_valid == e_trap, req, "trap_valid", 32'(trap_valid), 32'(e_trap));
    chk(trap_code == e_code, req, "trap_code", 32'(trap_code), 32'(e_code));
    chk(lane_done == e_done, req, "lane_done", 32'(lane_done), 32'(e_done));
    chk(fpc_we == !e_trap && dest_we == !e_trap, req, "fpc_we/dest_we",
        {30'd0, fpc_we, dest_we}, {30'd0, !e_trap, !e_trap});
    chk(fpc_out == e_fpc, req, "fpc_out", fpc_out, e_fpc);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: quiet outputs after reset
    chk(!rsp_valid && !trap_valid && !fpc_we && !dest_we && trap_code == 0 && lane_done == 0,
        "R1", "idle outputs", {rsp_valid, trap_valid, fpc_we, dest_we, trap_code, lane_done}, 32'd0);

    // R3: low bits 2:0 ignored even with all enables set
    run(16'h0707, 32'hFF00_0000, 0, 0, 0, "R3");
    // R3: enabled overflow in lane 0 traps
    run(16'h0020, 32'h2000_0000, 0, 0, 0, "R3");
    // R4: invalid beats inexact
    run(16'h0088, 32'hFF00_0000, 0, 0, 0, "R4");
    // R4: inexact alone gives cause 5
    run(16'h0008, 32'h0800_0000, 0, 0, 0, "R4");
    // R4: overflow beats underflow
    run(16'h0030, 32'h3000_0000, 0, 0, 0, "R4");
    // R5: lane 1 overflow, lane 0 clean -> code 0x13
    run(16'h2000, 32'h2000_0000, 0, 0, 0, "R5");
    // R6: inexact suppressed in lane 0, lane 1 div-by-zero -> 0x12
    run(16'h4008, 32'hFF00_0000, 0, 1, 0, "R6");
    // R6: inexact only, suppressed -> no trap, flags merged
    run(16'h0808, 32'h0800_0000, 0, 1, 0, "R6");
    // R7: lane 0 traps, lane 1 not processed or merged
    run(16'h8040, 32'h4000_0000, 0, 0, 0, "R7");
    // R8: single element, lane 1 would trap
    run(16'h8010, 32'h8000_0000, 1, 0, 0, "R8");
    // R9: widening index doubling, lane 1 underflow -> 0x24
    run(16'h1000, 32'h1000_0000, 0, 0, 1, "R9");
    // R10: no enables, both lanes merge
    run(16'h2890, 32'h0001_0203, 0, 0, 0, "R10");
    // R11: trap leaves control word as given
    run(16'h00F8, 32'hF8AA_5501, 0, 0, 0, "R11");
    // R12: all-zero lanes
    run(16'h0000, 32'hFF12_3456, 0, 0, 0, "R12");
    @(negedge clk);
    chk(!rsp_valid && !fpc_we, "R1", "idle after response", {30'd0, rsp_valid, fpc_we}, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] fl; logic [31:0] fpc; logic [31:0] r;
      r   = $urandom;
      fl  = 16'($urandom);
      fpc = $urandom;
      if (r[3:0] == 4'd0) fl[7:0] = 8'h00;
      if (r[7:4] == 4'd0) fpc[31:24] = 8'h00;
      run(fl, fpc, r[8] & r[9], r[10], r[11], "R7");
      if (r[12]) @(negedge clk);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule